// File: doc/BRIEF.md
# Transition-Mode PFC Switching Sequencer

This block is the digital timing core of a boost power-factor-correction controller that runs in critical conduction. It receives three comparator flags: zero-crossing armed (the sense winding is above its high threshold), zero-crossing triggered (the winding is below its low threshold) and over-current. It also receives an unsigned on-time command that stands in for the compensation voltage, and an enable. From these it produces the gate output for the external switch.

A switching cycle begins only when the off-time was first opened by an armed edge and then closed by a trigger edge. The gate then stays high for a time set by the command. A current-sense flag that arrives outside a blanking window at the start of the pulse ends the pulse at once. If the zero-crossing pair never arrives, a restart timer forces pulses of the commanded length at a fixed interval. All timing is counted in system clock cycles.

Top module: `tm_pfc_seq`

## Requirements
- R1: While reset is low the gate is low. After reset releases with enable high and no comparator activity, the gate stays low until the restart timer first expires.
- R2: A rising edge of the trigger flag starts a pulse only if a rising edge of the armed flag has been seen since the last turn-on. The gate goes high on the third rising clock edge that samples the trigger flag high, counting the first such edge; the two-flop synchronizer accounts for this delay.
- R3: A trigger edge with no armed edge since the last turn-on does not start a pulse.
- R4: A pulse that runs to its end is high for exactly TON_MIN_CYC + floor(cmd*(TON_MAX_CYC-TON_MIN_CYC)/(2^CMD_W-1)) cycles, where cmd is the command value at the turn-on edge. This holds for forced pulses too.
- R5: With no valid zero-crossing pair, turn-ons are forced every WDOG_CYC cycles, counted from one rising gate edge to the next.
- R6: The restart timer restarts at every turn-on, whatever caused it. A forced pulse therefore comes WDOG_CYC cycles after the last zero-crossing turn-on.
- R7: The over-current flag has no effect while fewer than BLANK_CYC cycles of the pulse have passed.
- R8: A synchronized over-current flag seen after the blanking window drives the gate low on the next edge. With the flag held high, a pulse lasts BLANK_CYC+1 cycles.
- R9: After a current-limit abort the gate stays low until a new armed-then-trigger pair or a forced restart. A lone trigger edge does not restart it.
- R10: With enable low the gate goes low on the next edge and no pulse starts. The armed state and the restart timer are cleared, so after enable returns the first forced pulse comes WDOG_CYC cycles later.
- R11: The armed state is cleared at every turn-on. An armed edge seen before a forced turn-on does not qualify a trigger edge after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Run enable; low holds the gate off and clears the sequencer |
| zx_arm_i | input | 1 | Asynchronous flag: sense winding above the arm threshold |
| zx_trig_i | input | 1 | Asynchronous flag: sense winding below the trigger threshold |
| oc_i | input | 1 | Asynchronous over-current flag |
| ton_cmd_i | input | CMD_W | Unsigned on-time command |
| gate_o | output | 1 | Gate drive request |

## Verification
The bench targets the ordering of the zero-crossing pair. A trigger edge alone, and an armed edge that a forced pulse has already consumed, must both be rejected; a design that remembers the arm too long would start pulses from ringing. It also checks the exact synchronizer latency and the end points of the on-time map, where an off-by-one in the counter shows up as a pulse one cycle too long or too short. Over-current pulses are placed inside and just past the blanking window, and the restart interval is measured from both kinds of turn-on. A design that did not restart its timer at zero-crossing turn-ons would insert forced pulses in the middle of normal switching.

// File: rtl/tm_pfc_pkg.sv
// Package: shared types for the transition-mode PFC sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package tm_pfc_pkg;

    // Comparator flags grouped in one vector for synchronization.
    typedef struct packed {
        logic oc;
        logic trig;
        logic arm;
    } cmp_flags_t;

    // Reason a pulse starts on a given cycle.
    typedef enum logic [1:0] {
        START_NONE = 2'd0,
        START_ZX   = 2'd1,
        START_WDOG = 2'd2
    } start_t;

endpackage

// File: rtl/tm_pfc_sync.sv
// Module: multi-stage synchronizer for asynchronous comparator flags.
// Each bit passes through STAGES flops. Reset clears every stage.
// Assumes: the flags are level signals that stay stable for several cycles.
module tm_pfc_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] level_o
);

    logic [STAGES-1:0][N-1:0] stg_q;

    // Shift the raw flags through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_q <= '0;
        end else begin
            stg_q[0] <= async_i;
            for (int s = 1; s < STAGES; s++) begin
                stg_q[s] <= stg_q[s-1];
            end
        end
    end

    assign level_o = stg_q[STAGES-1];

endmodule

// File: rtl/tm_pfc_edge.sv
// Module: rising-edge detector for synchronized flags.
// rise_o is high for one cycle when a level goes from 0 to 1.
// Assumes: the inputs are already in the clk domain.
module tm_pfc_edge #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] level_i,
    output logic [N-1:0] rise_o
);

    logic [N-1:0] prev_q;

    // Remember last cycle's level for each bit.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= level_i;
    end

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_rise
            assign rise_o[g] = level_i[g] & ~prev_q[g];
        end
    endgenerate

endmodule

// File: rtl/tm_pfc_ontime.sv
// Module: maps the unsigned on-time command to a pulse length in cycles.
// Linear map: the lowest code gives TON_MIN_CYC and the highest gives
// TON_MAX_CYC. Rounds down.
// Assumes: TON_MAX_CYC > TON_MIN_CYC >= 1. The divisor is a constant.
module tm_pfc_ontime #(
    parameter  int CMD_W       = 8,
    parameter  int TON_MIN_CYC = 15,
    parameter  int TON_MAX_CYC = 2500,
    localparam int CNT_W       = $clog2(TON_MAX_CYC + 1)
) (
    input  logic [CMD_W-1:0] cmd_i,
    output logic [CNT_W-1:0] ton_len_o
);

    localparam int SPAN    = TON_MAX_CYC - TON_MIN_CYC;
    localparam int CMD_MAX = (1 << CMD_W) - 1;
    localparam int PROD_W  = CMD_W + $clog2(SPAN + 1);

    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] quot;

    // Scale the command across the on-time span, then offset by the minimum.
    always_comb begin
        prod      = PROD_W'(cmd_i) * PROD_W'(SPAN);
        quot      = prod / PROD_W'(CMD_MAX);
        ton_len_o = CNT_W'(TON_MIN_CYC) + CNT_W'(quot);
    end

endmodule

// File: rtl/tm_pfc_ctrl.sv
// Module: switching sequencer core. It holds the gate state, the on-time
// counter, the armed flag and the restart timer.
// A pulse starts on an armed-then-trigger pair or when the restart timer
// expires. It ends when the latched length runs out, or on over-current
// after the blanking window.
// Assumes: the inputs are synchronized. BLANK_CYC < TON_MAX_CYC and
// WDOG_CYC > TON_MAX_CYC.
module tm_pfc_ctrl
    import tm_pfc_pkg::*;
#(
    parameter  int TON_MIN_CYC = 15,
    parameter  int TON_MAX_CYC = 2500,
    parameter  int BLANK_CYC   = 16,
    parameter  int WDOG_CYC    = 20000,
    localparam int CNT_W       = $clog2(TON_MAX_CYC + 1),
    localparam int WD_W        = $clog2(WDOG_CYC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             arm_rise_i,
    input  logic             trig_rise_i,
    input  logic             oc_lvl_i,
    input  logic [CNT_W-1:0] ton_len_i,
    output logic             gate_o
);

    localparam logic [CNT_W-1:0] BLANK_L = CNT_W'(BLANK_CYC);
    localparam logic [CNT_W-1:0] MIN_L   = CNT_W'(TON_MIN_CYC);
    localparam logic [CNT_W-1:0] MAX_L   = CNT_W'(TON_MAX_CYC);
    localparam logic [WD_W-1:0]  WD_LAST = WD_W'(WDOG_CYC - 1);

    logic             gate_q;
    logic             arm_q;
    logic [CNT_W-1:0] on_cnt;
    logic [CNT_W-1:0] ton_q;
    logic [WD_W-1:0]  wd_cnt;
    start_t           start_cause;
    logic             start;
    logic             len_done;
    logic             oc_cut;

    // Decide whether a pulse starts this cycle, and why.
    always_comb begin
        start_cause = START_NONE;
        if (en_i && !gate_q) begin
            if (arm_q && trig_rise_i)  start_cause = START_ZX;
            else if (wd_cnt == WD_LAST) start_cause = START_WDOG;
        end
    end

    assign start    = (start_cause != START_NONE);
    assign len_done = gate_q && (on_cnt == ton_q - CNT_W'(1));
    assign oc_cut   = gate_q && oc_lvl_i && (on_cnt >= BLANK_L);

    // Gate state: set on a start, cleared at end of length, on over-current or on disable.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i)        gate_q <= 1'b0;
        else if (start)             gate_q <= 1'b1;
        else if (len_done || oc_cut) gate_q <= 1'b0;
    end

    // On-time counter: zero at turn-on, counts during the pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   on_cnt <= '0;
        else if (start)                               on_cnt <= '0;
        else if (gate_q && !len_done && !oc_cut)      on_cnt <= on_cnt + CNT_W'(1);
    end

    // Latch the commanded pulse length at turn-on.
    always_ff @(posedge clk) begin
        if (!rst_n)     ton_q <= MIN_L;
        else if (start) ton_q <= ton_len_i;
    end

    // Armed flag: set by an armed edge, cleared by turn-on or disable.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) arm_q <= 1'b0;
        else if (start)      arm_q <= 1'b0;
        else if (arm_rise_i) arm_q <= 1'b1;
    end

    // Restart timer: zero at each turn-on, saturates at its last count.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i)     wd_cnt <= '0;
        else if (start)          wd_cnt <= '0;
        else if (wd_cnt != WD_LAST) wd_cnt <= wd_cnt + WD_W'(1);
    end

    assign gate_o = gate_q;

    // R10: disable forces the gate low on the next edge.
    a_r10_dis_gate_low: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !gate_q);

    // R4: the on-time counter never passes the latched length.
    a_r4_on_bound: assert property (@(posedge clk) disable iff (!rst_n)
        gate_q |-> (on_cnt < ton_q));

    // R4: the latched length lies within the clamp.
    a_r4_ton_range: assert property (@(posedge clk) disable iff (!rst_n)
        gate_q |-> (ton_q >= MIN_L && ton_q <= MAX_L));

    // R11: the armed flag is cleared at every turn-on.
    a_r11_arm_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_q) |-> !arm_q);

    // R6: the restart timer is at zero just after any turn-on.
    a_r6_wd_restart: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_q) |-> (wd_cnt == '0));

    // R2/R5: a turn-on needs an armed trigger edge or an expired timer.
    a_r2_start_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_q) |-> ($past(arm_q && trig_rise_i) || ($past(wd_cnt) == WD_LAST)));

    // R7: a pulse never ends early inside the blanking window.
    a_r7_blank: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gate_q) |-> (!$past(en_i) || ($past(on_cnt) == $past(ton_q) - CNT_W'(1))
                           || ($past(on_cnt) >= BLANK_L)));

    // R8: over-current after blanking ends the pulse on the next edge.
    a_r8_oc_cut: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_q && oc_lvl_i && (on_cnt >= BLANK_L)) |=> !gate_q);

    // R5: the restart timer stays within its range.
    a_r5_wd_range: assert property (@(posedge clk) disable iff (!rst_n)
        wd_cnt <= WD_LAST);

endmodule

// File: rtl/tm_pfc_seq.sv
// Module: top of the transition-mode PFC switching sequencer.
// It synchronizes the comparator flags, detects the zero-crossing edges,
// maps the on-time command and runs the sequencer core.
// Assumes: timing parameters are in clk cycles (defaults for 50 MHz:
// 0.3 us min, 50 us max, 320 ns blanking, 400 us restart).
module tm_pfc_seq
    import tm_pfc_pkg::*;
#(
    parameter int CMD_W       = 8,
    parameter int TON_MIN_CYC = 15,
    parameter int TON_MAX_CYC = 2500,
    parameter int BLANK_CYC   = 16,
    parameter int WDOG_CYC    = 20000,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             zx_arm_i,
    input  logic             zx_trig_i,
    input  logic             oc_i,
    input  logic [CMD_W-1:0] ton_cmd_i,
    output logic             gate_o
);

    localparam int CNT_W = $clog2(TON_MAX_CYC + 1);
    localparam int NFLAG = $bits(cmp_flags_t);

    cmp_flags_t       raw_flags;
    cmp_flags_t       sync_flags;
    logic [1:0]       zx_rise;
    logic [CNT_W-1:0] ton_len;

    assign raw_flags.arm  = zx_arm_i;
    assign raw_flags.trig = zx_trig_i;
    assign raw_flags.oc   = oc_i;

    tm_pfc_sync #(
        .N      (NFLAG),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_flags),
        .level_o (sync_flags)
    );

    tm_pfc_edge #(
        .N (2)
    ) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i ({sync_flags.trig, sync_flags.arm}),
        .rise_o  (zx_rise)
    );

    tm_pfc_ontime #(
        .CMD_W       (CMD_W),
        .TON_MIN_CYC (TON_MIN_CYC),
        .TON_MAX_CYC (TON_MAX_CYC)
    ) u_ontime (
        .cmd_i     (ton_cmd_i),
        .ton_len_o (ton_len)
    );

    tm_pfc_ctrl #(
        .TON_MIN_CYC (TON_MIN_CYC),
        .TON_MAX_CYC (TON_MAX_CYC),
        .BLANK_CYC   (BLANK_CYC),
        .WDOG_CYC    (WDOG_CYC)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (en_i),
        .arm_rise_i  (zx_rise[0]),
        .trig_rise_i (zx_rise[1]),
        .oc_lvl_i    (sync_flags.oc),
        .ton_len_i   (ton_len),
        .gate_o      (gate_o)
    );

endmodule

// File: tb/tm_pfc_seq_tb_top.sv
// Bench: a behavioural reference model compared every cycle, plus directed
// measurements of latency, widths and restart intervals.
module tm_pfc_seq_tb_top;

    localparam int CW    = 4;
    localparam int TMIN  = 4;
    localparam int TMAX  = 40;
    localparam int BLANK = 6;
    localparam int WDOG  = 100;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0;
    logic          zx_arm = 1'b0;
    logic          zx_trig = 1'b0;
    logic          oc = 1'b0;
    logic [CW-1:0] cmd = 4'd5;
    logic          gate;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tm_pfc_seq #(
        .CMD_W (CW), .TON_MIN_CYC (TMIN), .TON_MAX_CYC (TMAX),
        .BLANK_CYC (BLANK), .WDOG_CYC (WDOG)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .en_i (en), .zx_arm_i (zx_arm),
        .zx_trig_i (zx_trig), .oc_i (oc), .ton_cmd_i (cmd), .gate_o (gate)
    );

    function automatic int ton_of(int c);
        return TMIN + (c * (TMAX - TMIN)) / ((1 << CW) - 1);
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reference model: raw history queues stand for the synchronizer delay.
    bit q_arm[$] = '{0, 0, 0};
    bit q_trig[$] = '{0, 0, 0};
    bit q_oc[$] = '{0, 0, 0};
    int m_gate = 0, m_arm = 0, m_on = 0, m_ton = TMIN, m_wd = 0;

    always @(posedge clk) begin
        bit a_r, t_r, oc_s;
        if (!rst_n) begin
            q_arm = '{0, 0, 0}; q_trig = '{0, 0, 0}; q_oc = '{0, 0, 0};
            m_gate = 0; m_arm = 0; m_on = 0; m_ton = TMIN; m_wd = 0;
        end else begin
            a_r  = q_arm[1] && !q_arm[2];
            t_r  = q_trig[1] && !q_trig[2];
            oc_s = q_oc[1];
            if (!en) begin
                m_gate = 0; m_arm = 0; m_wd = 0;
            end else if (!m_gate && ((m_arm && t_r) || m_wd == WDOG - 1)) begin
                m_gate = 1; m_on = 0; m_ton = ton_of(int'(cmd)); m_arm = 0; m_wd = 0;
            end else begin
                if (m_gate) begin
                    if (m_on == m_ton - 1 || (oc_s && m_on >= BLANK)) m_gate = 0;
                    else m_on++;
                end
                if (a_r) m_arm = 1;
                if (m_wd < WDOG - 1) m_wd++;
            end
            q_arm.push_front(zx_arm);  void'(q_arm.pop_back());
            q_trig.push_front(zx_trig); void'(q_trig.pop_back());
            q_oc.push_front(oc);       void'(q_oc.pop_back());
        end
    end

    // Cycle compare away from the active edge (covers R2, R4, R5, R8, R10).
    always @(negedge clk) begin
        if (!done) chk("R2/R4/R5/R8/R10 model-compare", int'(gate), m_gate);
    end

    task automatic wait_rise(input int lim, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!gate && n < lim);
        if (!gate) n = -1;
    endtask

    // Width of a pulse seen high at this negedge; optional over-current window.
    task automatic meas_oc(input int d_on, input int d_off, output int w);
        w = 1;
        forever begin
            if (w == d_on + 1) oc = 1'b1;
            if (w == d_off + 1) oc = 1'b0;
            @(negedge clk);
            if (gate && w < 1000) w++;
            else break;
        end
        oc = 1'b0;
    endtask

    task automatic meas(output int w);
        meas_oc(100000, 100000, w);
    endtask

    task automatic zx_seq(input bit do_arm, output int lat);
        if (do_arm) begin
            zx_arm = 1'b1; repeat (3) @(negedge clk);
            zx_arm = 1'b0; repeat (2) @(negedge clk);
        end
        zx_trig = 1'b1;
        wait_rise(20, lat);
        zx_trig = 1'b0;
    endtask

    initial begin
        #(10 * 200000);
        if (!done) begin
            done = 1'b1;
            failures++;
            $display("FAIL timeout actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int n, w, w2, lat;
        repeat (3) @(negedge clk);
        chk("R1 gate low in reset", int'(gate), 0);
        rst_n = 1'b1; en = 1'b1;
        wait_rise(300, n);
        chk("R1/R5 first forced turn-on delay", n, WDOG);
        meas(w);
        chk("R4 forced pulse width cmd=5", w, ton_of(5));

        cmd = 4'd15;
        zx_seq(1'b1, lat);
        chk("R2 trigger-to-gate latency", lat, 3);
        meas(w);
        chk("R4 max width cmd=15", w, TMAX);

        cmd = 4'd0;
        repeat (4) begin
            zx_seq(1'b1, lat);
            chk("R2 repeated zx latency", lat, 3);
            meas(w);
            chk("R4 min width cmd=0", w, TMIN);
        end
        wait_rise(300, n);
        chk("R6 restart timed from zx turn-on", w + n, WDOG);
        cmd = 4'd7;
        meas(w2);
        wait_rise(300, n);
        chk("R5 forced period", w2 + n, WDOG);
        meas(w);
        chk("R4 forced pulse uses new cmd=7", w, ton_of(7));

        zx_seq(1'b0, lat);
        chk("R3 trigger without arm ignored", lat, -1);
        zx_seq(1'b1, lat);
        chk("R2 arm then trigger after ignored one", lat, 3);
        meas(w);

        zx_arm = 1'b1; repeat (3) @(negedge clk); zx_arm = 1'b0;
        wait_rise(300, n);
        chk("R11 forced turn-on happens", int'(n > 0), 1);
        meas(w);
        zx_seq(1'b0, lat);
        chk("R11 stale arm does not qualify trigger", lat, -1);

        cmd = 4'd15;
        zx_seq(1'b1, lat);
        meas_oc(0, 2, w);
        chk("R7 over-current inside blanking ignored", w, TMAX);

        zx_seq(1'b1, lat);
        meas_oc(10, 100000, w);
        chk("R8 over-current mid pulse width", w, 13);

        oc = 1'b1;
        zx_seq(1'b1, lat);
        meas_oc(100000, 100000, w);
        chk("R8 over-current held high width", w, BLANK + 1);
        oc = 1'b0;
        zx_seq(1'b0, lat);
        chk("R9 lone trigger after abort ignored", lat, -1);
        zx_seq(1'b1, lat);
        chk("R9 arm then trigger after abort", lat, 3);

        repeat (5) @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        chk("R10 gate low after disable", int'(gate), 0);
        zx_seq(1'b1, lat);
        chk("R10 no zx start while disabled", lat, -1);
        wait_rise(150, n);
        chk("R10 no forced start while disabled", n, -1);
        en = 1'b1;
        wait_rise(300, n);
        chk("R10 restart timer cleared by disable", n, WDOG);
        meas(w);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule